// File: doc/BRIEF.md
# Paged Memory-Map Decoder with ROM Overlays

This block decodes the 16-bit address of an 8-bit processor into four targets: on-chip ROM, external ROM, external RAM and an I/O region. It also forms the 18-bit address that goes to the external memory devices. The 64K space is split into sixteen 4K blocks. Blocks A and E are windows, and each one can be paged independently to any of the 64 4K pages of a 256K external device. All other ROM blocks pass their address straight through. As a result, device pages 12 to 15 line up with C000 to FFFF.

Two 16-bit override masks hold one bit per block, and they change which memory sits behind a block:

- Masking a block out of on-chip ROM sends its accesses to external memory.
- Masking a block out of external ROM sends its accesses to external RAM, at the same address the ROM would have used, paging included.

Firmware can therefore be shadowed in RAM, changed, and run from there. A reset brings the on-chip ROMs back.

The page registers and the masks are written and read back at fixed addresses inside the I/O block. A write takes effect on the cycle after it.

Top module: `paged_map_decoder`

## Requirements
- R1: With both masks clear, a valid access selects by block: blocks 0 to 9 select external RAM; block A selects external ROM; block B selects I/O; block C selects on-chip ROM; block D selects external ROM; block E selects external ROM; block F selects on-chip ROM.
- R2: After reset, the block-A page reads 10 and the block-E page reads 14.
- R3: An access to block A drives ext_addr = {pageA[5:0], cpu_addr[11:0]}, and an access to block E drives ext_addr = {pageE[5:0], cpu_addr[11:0]}. This holds whichever target is selected.
- R4: An access to any block other than A or E drives ext_addr = {2'b00, cpu_addr[15:0]}.
- R5: Bit n of the on-chip-disable mask moves block n (C or F) from on-chip ROM to external ROM. If the external-disable bit of that block is also set, the block goes to external RAM instead.
- R6: Bit n of the external-disable mask moves block n (A, C, D, E or F) from external ROM to external RAM, and ext_addr is unchanged.
- R7: Mask bits for blocks that hold no ROM of the relevant kind have no effect. This applies to blocks 0 to 9 and B in both masks, and to blocks A, D and E in the on-chip mask.
- R8: During a valid cycle exactly one of the four selects is high. When cpu_valid is low, all four selects are low.
- R9: mem_we is high only for a valid write that selects external RAM or I/O. A write to on-chip or external ROM raises no write strobe.
- R10: The configuration registers sit at fixed I/O offsets and are written with cpu_valid and cpu_we:
  - BFF0 holds the block-A page.
  - BFF1 holds the block-E page.
  - BFF2 and BFF3 hold the low and high bytes of the on-chip-disable mask.
  - BFF4 and BFF5 hold the low and high bytes of the external-disable mask.
  
  reg_rdata returns the addressed register, with page bits 7:6 reading 0, and reads 0 at any other address. A write is first seen by the decode on the next cycle.
- R11: Reset clears both masks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | A bus cycle is in progress |
| cpu_we | input | 1 | The cycle is a write |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| reg_rdata | output | 8 | Readback of the configuration register at cpu_addr |
| sel_irom | output | 1 | On-chip ROM select |
| sel_xrom | output | 1 | External ROM select |
| sel_xram | output | 1 | External RAM select |
| sel_io | output | 1 | I/O region select |
| mem_we | output | 1 | Write strobe for RAM or I/O |
| ext_addr | output | 18 | External memory address |

## Verification
Two functions can fall in the same cycle: a configuration write, and a decode that the same write would change. For example, the CPU writes a page or mask and, in the very next cycle, accesses the block that the write affects.

The bench provokes this directly, and random writes to BFF0 to BFF5 are interleaved with random accesses. The bench model applies each write only after the cycle that carries it, so the decode in the write cycle itself must still show the old setting, and the following cycle must show the new one.

Blocks that have both mask bits set at once are also exercised, and the select is judged against the layered priority described in R5.

// File: rtl/paged_map_decoder.sv
module paged_map_decoder #(
  parameter int AW      = 16,
  parameter int DW      = 8,
  parameter int BLK_W   = 4,
  parameter int PAGE_W  = 6,
  parameter int XAW     = 18,
  parameter logic [AW-1:0]     CFG_BASE   = 16'hBFF0,
  parameter logic [PAGE_W-1:0] PAGE_A_RST = 6'd10,
  parameter logic [PAGE_W-1:0] PAGE_E_RST = 6'd14,
  parameter logic [BLK_W-1:0]  BLK_WIN_A  = 4'hA,
  parameter logic [BLK_W-1:0]  BLK_IO     = 4'hB,
  parameter logic [BLK_W-1:0]  BLK_BASIC  = 4'hC,
  parameter logic [BLK_W-1:0]  BLK_FP     = 4'hD,
  parameter logic [BLK_W-1:0]  BLK_WIN_E  = 4'hE,
  parameter logic [BLK_W-1:0]  BLK_KERNEL = 4'hF
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cpu_valid,
  input  logic           cpu_we,
  input  logic [AW-1:0]  cpu_addr,
  input  logic [DW-1:0]  cpu_wdata,
  output logic [DW-1:0]  reg_rdata,
  output logic           sel_irom,
  output logic           sel_xrom,
  output logic           sel_xram,
  output logic           sel_io,
  output logic           mem_we,
  output logic [XAW-1:0] ext_addr
);
  localparam int NBLK  = 1 << BLK_W;
  localparam int OFS_W = AW - BLK_W;
  localparam int IDX_W = 3;

  logic [PAGE_W-1:0] page_a, page_e;
  logic [NBLK-1:0]   irom_off, xrom_off;

  wire [BLK_W-1:0] blk     = cpu_addr[AW-1 -: BLK_W];
  wire [OFS_W-1:0] ofs     = cpu_addr[OFS_W-1:0];
  wire             cfg_hit = cpu_addr[AW-1:IDX_W] == CFG_BASE[AW-1:IDX_W];
  wire [IDX_W-1:0] idx     = cpu_addr[IDX_W-1:0];
  wire             cfg_wr  = cpu_valid & cpu_we & cfg_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_a   <= PAGE_A_RST;
      page_e   <= PAGE_E_RST;
      irom_off <= '0;
      xrom_off <= '0;
    end else if (cfg_wr) begin
      case (idx)
        3'd0: page_a         <= cpu_wdata[PAGE_W-1:0];
        3'd1: page_e         <= cpu_wdata[PAGE_W-1:0];
        3'd2: irom_off[7:0]  <= cpu_wdata;
        3'd3: irom_off[15:8] <= cpu_wdata;
        3'd4: xrom_off[7:0]  <= cpu_wdata;
        3'd5: xrom_off[15:8] <= cpu_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (cfg_hit) begin
      case (idx)
        3'd0: reg_rdata = {{(DW-PAGE_W){1'b0}}, page_a};
        3'd1: reg_rdata = {{(DW-PAGE_W){1'b0}}, page_e};
        3'd2: reg_rdata = irom_off[7:0];
        3'd3: reg_rdata = irom_off[15:8];
        3'd4: reg_rdata = xrom_off[7:0];
        3'd5: reg_rdata = xrom_off[15:8];
        default: reg_rdata = '0;
      endcase
    end
  end

  wire is_io     = blk == BLK_IO;
  wire irom_home = (blk == BLK_BASIC) | (blk == BLK_KERNEL);
  wire rom_home  = irom_home | (blk == BLK_WIN_A) | (blk == BLK_FP) | (blk == BLK_WIN_E);
  wire hit_irom  = irom_home & ~irom_off[blk];
  wire hit_xrom  = rom_home & ~hit_irom & ~xrom_off[blk];
  wire hit_xram  = ~is_io & ~hit_irom & ~hit_xrom;

  assign sel_io   = cpu_valid & is_io;
  assign sel_irom = cpu_valid & hit_irom;
  assign sel_xrom = cpu_valid & hit_xrom;
  assign sel_xram = cpu_valid & hit_xram;
  assign mem_we   = cpu_valid & cpu_we & (is_io | hit_xram);

  assign ext_addr = (blk == BLK_WIN_A) ? {page_a, ofs} :
                    (blk == BLK_WIN_E) ? {page_e, ofs} :
                    {{(XAW-AW){1'b0}}, cpu_addr};
endmodule

// File: rtl/map_decoder_checks.sv
module map_decoder_checks #(
  parameter logic [3:0] CK_WIN_A = 4'hA,
  parameter logic [3:0] CK_IO    = 4'hB,
  parameter logic [3:0] CK_BASIC = 4'hC,
  parameter logic [3:0] CK_WIN_E = 4'hE,
  parameter logic [3:0] CK_KERN  = 4'hF
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_valid,
  input logic [15:0] cpu_addr,
  input logic        sel_irom,
  input logic        sel_xrom,
  input logic        sel_xram,
  input logic        sel_io,
  input logic        mem_we,
  input logic [17:0] ext_addr
);
  wire [3:0] cblk = cpu_addr[15:12];

  a_r8_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_valid |-> $onehot({sel_irom, sel_xrom, sel_xram, sel_io}));
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_valid |-> ({sel_irom, sel_xrom, sel_xram, sel_io} == 4'b0));
  a_r9_no_rom_write: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_irom || sel_xrom) |-> !mem_we);
  a_r3_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_valid |-> ext_addr[11:0] == cpu_addr[11:0]);
  a_r4_flat_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cblk != CK_WIN_A && cblk != CK_WIN_E) |-> ext_addr == {2'b00, cpu_addr});
  a_r1_io_block: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cblk == CK_IO) |-> sel_io);
  a_r5_irom_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    sel_irom |-> (cblk == CK_BASIC || cblk == CK_KERN));
  a_r7_low_ram: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cblk <= 4'd9) |-> sel_xram);
endmodule

bind paged_map_decoder map_decoder_checks u_chk (.*);

// File: tb/sim_paged_map_decoder.sv
`timescale 1ns/1ps
module sim_paged_map_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_valid = 1'b0, cpu_we = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        sel_irom, sel_xrom, sel_xram, sel_io, mem_we;
  logic [17:0] ext_addr;

  int checks = 0, failures = 0;
  logic [5:0]  m_pa = 6'd10, m_pe = 6'd14;
  logic [15:0] m_id = '0, m_xd = '0;

  always #2.5 clk = ~clk;

  paged_map_decoder u0 (.*);

  function automatic logic [3:0] exp_sel(input logic v, input logic [15:0] a);
    logic [3:0] b = a[15:12];
    logic ih = (b == 4'hC) || (b == 4'hF);
    logic rh = ih || b == 4'hA || b == 4'hD || b == 4'hE;
    if (!v) return 4'b0000;
    if (b == 4'hB) return 4'b0001;
    if (ih && !m_id[b]) return 4'b1000;
    if (rh && !m_xd[b]) return 4'b0100;
    return 4'b0010;
  endfunction

  function automatic logic [17:0] exp_addr(input logic [15:0] a);
    if (a[15:12] == 4'hA) return {m_pa, a[11:0]};
    if (a[15:12] == 4'hE) return {m_pe, a[11:0]};
    return {2'b00, a};
  endfunction

  function automatic logic [7:0] exp_rd(input logic [15:0] a);
    if (a[15:3] != 13'h17FE) return 8'h00;
    case (a[2:0])
      3'd0: return {2'b00, m_pa};
      3'd1: return {2'b00, m_pe};
      3'd2: return m_id[7:0];
      3'd3: return m_id[15:8];
      3'd4: return m_xd[7:0];
      3'd5: return m_xd[15:8];
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic v, input logic w, input logic [15:0] a,
                     input logic [7:0] d, input string st = "", input string rt = "R10");
    logic [3:0] b;
    string t;
    @(negedge clk);
    cpu_valid = v; cpu_we = w; cpu_addr = a; cpu_wdata = d;
    #1;
    b = a[15:12];
    if (st != "") t = st;
    else if (!v) t = "R8";
    else if ((b == 4'hC || b == 4'hF) && m_id[b]) t = "R5";
    else if ((b == 4'hA || b == 4'hC || b == 4'hD || b == 4'hE || b == 4'hF) && m_xd[b]) t = "R6";
    else t = "R1";
    chk(t, {28'b0, sel_irom, sel_xrom, sel_xram, sel_io}, {28'b0, exp_sel(v, a)});
    chk((b == 4'hA || b == 4'hE) ? "R3" : "R4", {14'b0, ext_addr}, {14'b0, exp_addr(a)});
    chk("R9", {31'b0, mem_we}, {31'b0, v & w & (exp_sel(v, a) inside {4'b0001, 4'b0010})});
    chk(rt, {24'b0, reg_rdata}, {24'b0, exp_rd(a)});
    if (v && w && a[15:3] == 13'h17FE) begin
      case (a[2:0])
        3'd0: m_pa = d[5:0];
        3'd1: m_pe = d[5:0];
        3'd2: m_id[7:0] = d;
        3'd3: m_id[15:8] = d;
        3'd4: m_xd[7:0] = d;
        3'd5: m_xd[15:8] = d;
        default: ;
      endcase
    end
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R2 / R11: reset values seen through readback
    cyc(0, 0, 16'hBFF0, 0, "", "R2");
    cyc(0, 0, 16'hBFF1, 0, "", "R2");
    for (int i = 2; i < 6; i++) cyc(0, 0, 16'hBFF0 + 16'(i), 0, "", "R11");
    // R1 default map, one access per block
    for (int i = 0; i < 16; i++) cyc(1, 0, {4'(i), 12'h5A5}, 0, "R1");
    // R3 new page takes effect one cycle later; high bits dropped on readback
    cyc(1, 1, 16'hBFF0, 8'hC5);
    cyc(1, 0, 16'hA123, 0);
    cyc(1, 0, 16'hBFF0, 0);
    cyc(1, 1, 16'hBFF1, 8'h3F);
    cyc(1, 0, 16'hEFFF, 0);
    // R9 ROM writes raise no strobe
    cyc(1, 1, 16'hC010, 8'h55, "R9");
    cyc(1, 1, 16'hD010, 8'h55, "R9");
    // R7: set every mask bit for blocks without such ROM
    cyc(1, 1, 16'hBFF2, 8'hFF);
    cyc(1, 1, 16'hBFF3, 8'h6F);
    cyc(1, 1, 16'hBFF4, 8'hFF);
    cyc(1, 1, 16'hBFF5, 8'h0B);
    cyc(1, 0, 16'h0000, 0, "R7");
    cyc(1, 1, 16'h9FFF, 8'h1, "R7");
    cyc(1, 0, 16'hB000, 0, "R7");
    cyc(1, 0, 16'hC000, 0, "R7");
    cyc(1, 0, 16'hA800, 0, "R7");
    // R5 kernel block to external ROM, then R6 on to RAM
    cyc(1, 1, 16'hBFF3, 8'h80);
    cyc(1, 0, 16'hF800, 0);
    cyc(1, 1, 16'hBFF5, 8'hC0);
    cyc(1, 0, 16'hF800, 0);
    cyc(1, 1, 16'hE010, 8'h7, "R6");
    cyc(1, 0, 16'hC100, 0);
    // R8 idle
    cyc(0, 1, 16'hC000, 0, "R8");
    // random mix
    for (int n = 0; n < 2000; n++) begin
      logic [15:0] a;
      logic v = ($urandom_range(9) != 0);
      if ($urandom_range(3) == 0) a = 16'hBFF0 + 16'($urandom_range(7));
      else a = 16'($urandom);
      cyc(v, 1'($urandom), a, 8'($urandom));
    end
    // reset restores defaults (R11)
    @(negedge clk); rst_n = 1'b0; m_pa = 6'd10; m_pe = 6'd14; m_id = '0; m_xd = '0;
    @(negedge clk); rst_n = 1'b1;
    cyc(1, 0, 16'hF000, 0, "R11");
    cyc(1, 0, 16'hBFF4, 0, "R11", "R11");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule